// File: doc/BRIEF.md
# Timestamped Spike Event Sequencer

This block replays a stream of timestamped address events onto an asynchronous address-event bus. A producer pushes entries through a valid/ready stream port, and each entry carries an event address together with a delay, counted in timer ticks, measured from the previous event. Entries wait in an internal queue. A scheduler takes them one at a time and releases each one when its moment arrives. It then presents the address and completes a four-phase request/acknowledge exchange with the receiver.

The delays are accumulated into an absolute target time that is compared against a free-running tick counter. A receiver that answers slowly on one event therefore only makes that event late. The events queued behind it keep their ideal timeline, and they are released at once if their time has already passed. When the queue runs dry and the scheduler is idle, the target follows the tick counter, so the next event's delay counts from the moment it is taken. The tick period is set by a 3-bit code. Each tick is a power-of-two multiple of a base period of `BASE_CYC` clock cycles, which is 30 ns at the default 200 MHz clock.

The stream port follows these back-pressure rules. A beat transfers on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low exactly while the queue is full. A beat offered while the queue is full is not held: it is discarded and raises the sticky overflow flag. A source that wants every beat delivered must therefore wait for `in_ready`.

Top module: `spike_seq`

## Requirements
- R1: After reset `fifo_empty` is 1, `fifo_full` is 0, `overflow` is 0, `bus_req` is 0 and `in_ready` is 1.
- R2: The queue accepts a beat when `in_valid` and `in_ready` are both high, and it holds `DEPTH` entries (128 by default). `fifo_full` rises when the last free slot is taken, `in_ready` equals the inverse of `fifo_full`, and `fifo_full` and `fifo_empty` are never both high.
- R3: A beat offered while `fifo_full` is high is discarded and never reaches the bus. `overflow` goes high on the next edge and stays high until reset.
- R4: Events appear on `bus_addr` in the order in which they were accepted, each carrying the `in_addr` value written with it.
- R5: One timer tick lasts `BASE_CYC * 2^k` clock cycles, where k equals `tick_sel` for codes 0 to 4 and k equals 4 for codes 5, 6 and 7.
- R6: An event that is not late rises `bus_req` exactly `in_delay` ticks after the scheduled time of the previous event.
- R7: An event made late by a slow acknowledge does not move the schedule of the events that follow it. The first event whose target has not yet passed still rises at its own scheduled time.
- R8: An event whose target has already passed, including any event with delay 0, rises `bus_req` no more than 6 clock cycles after `bus_ack` falls on the previous event.
- R9: `bus_addr` is stable for at least one cycle before `bus_req` rises and for as long as `bus_req` is high. `bus_req` stays high until `bus_ack` is seen high, then falls, and does not rise again while `bus_ack` is still high.
- R10: When the queue is empty and the bus is idle, the timeline restarts. An event written then rises `bus_req` between `3*P` and `4*P + 8` cycles after it is written with a delay of 4 ticks, where P is the tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream beat offered |
| in_ready | output | 1 | Queue can take a beat (not full) |
| in_addr | input | ADDR_W | Event address of the beat |
| in_delay | input | DLY_W | Ticks since the previous event |
| tick_sel | input | 3 | Tick period code |
| bus_addr | output | ADDR_W | Address presented on the event bus |
| bus_req | output | 1 | Event bus request |
| bus_ack | input | 1 | Event bus acknowledge |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| overflow | output | 1 | Sticky: a beat was dropped while full |

## Verification
The bus assertions assume that the receiver obeys the four-phase protocol: `bus_ack` rises only while `bus_req` is high and falls only after `bus_req` has dropped. The bench's responder raises and lowers the acknowledge only in reply to the request, after a chosen latency, so the stimulus never leaves that protocol. The timing checks assume that `tick_sel` is constant while events are pending, so the bench changes it only when the queue is drained and the scheduler is idle. The delays are kept far below half the range of the tick counter, which the wrap-safe comparison needs.

// File: rtl/spike_seq_pkg.sv
package spike_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_REQ,
    ST_REL
  } seq_state_e;

  // log2 of the tick multiplier; codes above 4 clamp to 16 base periods
  function automatic logic [2:0] tick_log2(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

endpackage

// File: rtl/spike_seq_fifo.sv
module spike_seq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spike_seq_timer.sv
module spike_seq_timer
  import spike_seq_pkg::*;
#(
  parameter int BASE_CYC = 6,
  parameter int TIME_W   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        tick_sel,
  output logic [TIME_W-1:0] now
);
  localparam int BW = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;

  logic [BW-1:0] bcnt;
  logic [4:0]    pcnt;
  logic [4:0]    div_m1;
  logic          base_en;
  logic          tick;

  assign base_en = (bcnt == BW'(BASE_CYC - 1));
  assign div_m1  = (5'd1 << tick_log2(tick_sel)) - 5'd1;
  assign tick    = base_en && (pcnt >= div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      pcnt <= '0;
      now  <= '0;
    end else begin
      bcnt <= base_en ? '0 : bcnt + 1'b1;
      if (base_en) pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) now <= now + 1'b1;
    end
  end
endmodule

// File: rtl/spike_seq_sched.sv
module spike_seq_sched
  import spike_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DLY_W  = 16,
  parameter int TIME_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic              ent_valid,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [DLY_W-1:0]  ent_dly,
  output logic              pop,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_req,
  input  logic              bus_ack
);
  seq_state_e        st;
  logic [TIME_W-1:0] target;
  logic [TIME_W-1:0] lag;
  logic [ADDR_W-1:0] addr_q;
  logic              due;

  // wrap-safe: due when now - target is non-negative as a signed value
  assign lag      = now - target;
  assign due      = !lag[TIME_W-1];
  assign pop      = (st == ST_IDLE) && ent_valid;
  assign bus_req  = (st == ST_REQ);
  assign bus_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      target <= '0;
      addr_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ent_valid) begin
            target <= target + TIME_W'(ent_dly);
            addr_q <= ent_addr;
            st     <= ST_WAIT;
          end else begin
            target <= now;
          end
        end
        ST_WAIT:  if (due) st <= ST_SETUP;
        ST_SETUP: st <= ST_REQ;
        ST_REQ:   if (bus_ack) st <= ST_REL;
        ST_REL:   if (!bus_ack) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spike_seq.sv
module spike_seq #(
  parameter int ADDR_W   = 16,
  parameter int DLY_W    = 16,
  parameter int DEPTH    = 128,
  parameter int BASE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DLY_W-1:0]  in_delay,
  input  logic [2:0]        tick_sel,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              overflow
);
  localparam int TIME_W = DLY_W + 2;
  localparam int EW     = ADDR_W + DLY_W;

  logic              wr_en;
  logic              pop;
  logic [EW-1:0]     head;
  logic [TIME_W-1:0] now;

  assign in_ready = !fifo_full;
  assign wr_en    = in_valid && !fifo_full;

  always_ff @(posedge clk) begin
    if (!rst_n)                      overflow <= 1'b0;
    else if (in_valid && fifo_full)  overflow <= 1'b1;
  end

  spike_seq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data({in_addr, in_delay}),
    .rd_en(pop), .rd_data(head),
    .empty(fifo_empty), .full(fifo_full)
  );

  spike_seq_timer #(.BASE_CYC(BASE_CYC), .TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .now(now)
  );

  spike_seq_sched #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .TIME_W(TIME_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .now(now),
    .ent_valid(!fifo_empty), .ent_addr(head[EW-1:DLY_W]), .ent_dly(head[DLY_W-1:0]),
    .pop(pop), .bus_addr(bus_addr), .bus_req(bus_req), .bus_ack(bus_ack)
  );
endmodule

// File: rtl/spike_seq_chk.sv
module spike_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              overflow,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr
);
  p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_overflow_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fifo_full) |=> overflow);

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_addr_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $stable(bus_addr));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> (!bus_req || $stable(bus_addr)));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req);

  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);

  p_no_req_ack_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && bus_ack) |=> !bus_req);
endmodule

bind spike_seq spike_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .overflow(overflow), .bus_req(bus_req),
  .bus_ack(bus_ack), .bus_addr(bus_addr)
);

// File: tb/spike_seq_bench.sv
`timescale 1ns/1ps
module spike_seq_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BC = 6;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, bus_ack = 0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_delay = '0;
  logic [2:0] tick_sel = '0;
  logic in_ready, bus_req, fifo_empty, fifo_full, overflow;
  logic [AW-1:0] bus_addr;

  always #2.5 clk = ~clk;

  spike_seq #(.ADDR_W(AW), .DLY_W(DW), .DEPTH(128), .BASE_CYC(BC)) u_spike_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_delay(in_delay), .tick_sel(tick_sel),
    .bus_addr(bus_addr), .bus_req(bus_req), .bus_ack(bus_ack),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int n_ev = 0, n_wr = 0;
  int stall_ev = -1;
  int rise_cyc [0:511];
  int fall_cyc [0:511];
  logic [AW-1:0] exp_addr [0:511];
  logic prev_req = 0;
  logic [AW-1:0] prev_addr = '0;
  int ack_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // event monitor: address order and setup (R4, R9)
  always @(negedge clk) begin
    if (rst_n && bus_req && !prev_req) begin
      rise_cyc[n_ev] = cyc;
      chk(bus_addr == exp_addr[n_ev], "R4 address order", int'(bus_addr), int'(exp_addr[n_ev]));
      chk(bus_addr == prev_addr, "R9 address setup", int'(bus_addr), int'(prev_addr));
      n_ev = n_ev + 1;
    end
    prev_req  = bus_req;
    prev_addr = bus_addr;
  end

  // four-phase responder
  always @(negedge clk) begin
    if (bus_req && !bus_ack) begin
      ack_cnt = ack_cnt + 1;
      if (ack_cnt >= ((n_ev - 1 == stall_ev) ? 100 : 2)) begin bus_ack = 1; ack_cnt = 0; end
    end else if (!bus_req && bus_ack) begin
      ack_cnt = ack_cnt + 1;
      if (ack_cnt >= 2) begin bus_ack = 0; ack_cnt = 0; fall_cyc[n_ev - 1] = cyc; end
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    in_valid = 1; in_addr = a; in_delay = d;
    if (in_ready) begin exp_addr[n_wr] = a; n_wr = n_wr + 1; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_events(input int n, input string req);
    int t = 0;
    while (n_ev < n && t < 20000) begin @(negedge clk); t++; end
    chk(n_ev >= n, req, n_ev, n);
    while (bus_req || bus_ack) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, p, ww;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(fifo_empty == 1, "R1 empty", int'(fifo_empty), 1);
    chk(fifo_full == 0, "R1 full", int'(fifo_full), 0);
    chk(overflow == 0, "R1 overflow", int'(overflow), 0);
    chk(bus_req == 0, "R1 req", int'(bus_req), 0);
    chk(in_ready == 1, "R1 ready", int'(in_ready), 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R5 / R6: tick period sweep over every code
    for (int s = 0; s < 8; s++) begin
      tick_sel = 3'(s);
      repeat (2) @(negedge clk);
      base = n_ev;
      push(16'(16'h100 + s), 16'd5);
      push(16'(16'h200 + s), 16'd5);
      wait_events(base + 2, "R5 sweep events");
      p = BC * (1 << ((s > 4) ? 4 : s));
      chk(rise_cyc[base + 1] - rise_cyc[base] == 5 * p, "R5 R6 tick spacing",
          rise_cyc[base + 1] - rise_cyc[base], 5 * p);
    end

    // R7: a stalled acknowledge does not shift the schedule
    tick_sel = 3'd0;
    repeat (2) @(negedge clk);
    base = n_ev;
    stall_ev = base + 1;
    push(16'h0A00, 16'd10);
    push(16'h0A01, 16'd10);
    push(16'h0A02, 16'd2);
    push(16'h0A03, 16'd20);
    wait_events(base + 4, "R7 events");
    stall_ev = -1;
    chk(rise_cyc[base + 1] - rise_cyc[base] == 60, "R6 on-time spacing",
        rise_cyc[base + 1] - rise_cyc[base], 60);
    chk(rise_cyc[base + 3] - rise_cyc[base] == 192, "R7 schedule kept after stall",
        rise_cyc[base + 3] - rise_cyc[base], 192);
    chk(rise_cyc[base + 2] - fall_cyc[base + 1] <= 6 && rise_cyc[base + 2] > fall_cyc[base + 1],
        "R8 late event released at once", rise_cyc[base + 2] - fall_cyc[base + 1], 6);

    // R2 / R3: fill, overflow, drain
    base = n_ev;
    push(16'h1000, 16'd200);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      if (i == 127) chk(fifo_full == 0, "R2 not full at 127", int'(fifo_full), 0);
      push(16'(16'h2000 + i), 16'd0);
    end
    chk(fifo_full == 1, "R2 full at depth", int'(fifo_full), 1);
    chk(in_ready == 0, "R2 ready low when full", int'(in_ready), 0);
    chk(fifo_empty == 0, "R2 not empty", int'(fifo_empty), 0);
    chk(overflow == 0, "R3 no overflow yet", int'(overflow), 0);
    push(16'hDEAD, 16'd0);
    chk(overflow == 1, "R3 overflow set", int'(overflow), 1);
    wait_events(base + 129, "R2 drain events");
    repeat (200) @(negedge clk);
    chk(n_ev == base + 129, "R3 dropped beat not replayed", n_ev, base + 129);
    chk(fifo_empty == 1, "R2 empty after drain", int'(fifo_empty), 1);
    chk(rise_cyc[base + 5] - fall_cyc[base + 4] <= 6 && rise_cyc[base + 5] > fall_cyc[base + 4],
        "R8 zero delay", rise_cyc[base + 5] - fall_cyc[base + 4], 6);
    chk(overflow == 1, "R3 overflow sticky", int'(overflow), 1);

    // R10: timeline restarts after idle
    tick_sel = 3'd1;
    repeat (50) @(negedge clk);
    base = n_ev;
    ww = cyc;
    push(16'h3333, 16'd4);
    wait_events(base + 1, "R10 event");
    chk(rise_cyc[base] - ww >= 36 && rise_cyc[base] - ww <= 56, "R10 restart delay",
        rise_cyc[base] - ww, 48);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule